// File: doc/BRIEF.md
# Idle Request Acknowledge Controller

This block answers a power manager's request to stop a peripheral's clocks. A request line arrives from the power manager. The block raises an acknowledge once the policy chosen by software allows the clocks to be cut. It also produces an enable for the gate on the peripheral's interface clock.

Software picks one of three policies by writing a configuration word. The first policy acknowledges at once. The second never acknowledges. The third waits until the peripheral reports that it has no outstanding bus transactions, interrupts, DMA requests or functional-clock activity. A second field applies only to the waiting policy. It decides whether interface-clock activity must also settle before the acknowledge is given, and whether that clock is switched off while the block is idle.

The acknowledge comes from a register. It stays high for as long as the request is held. The interface-clock enable comes back in the same cycle that the request is withdrawn.

Top module: `idle_ack_ctrl`

## Requirements
- R1: After reset the stored policy is never-acknowledge (value 1), the clock field is 0, `idle_ack_o` is 0 and `iclk_en_o` is 1. A clock edge with `cfg_wr_i` high stores the policy from `cfg_wdata_i[4:3]` and the clock field from `cfg_wdata_i[9:8]`. The new values apply from the next edge.
- R2: With policy 0 (immediate), a request sampled at an edge sets `idle_ack_o` after that edge, whatever the activity flags show.
- R3: With policy 1 (never) or policy 3 (reserved), `idle_ack_o` never rises.
- R4: With policy 2 (waiting) and clock field 0, `idle_ack_o` rises only after an edge at which the request is high and all five activity flags are low. Any single flag held high keeps it low.
- R5: With policy 2 and a nonzero clock field, `iclk_busy_i` is ignored. The other four flags still hold the acknowledge back.
- R6: Once `idle_ack_o` is high it stays high while `idle_req_i` stays high. This holds even if activity resumes or the configuration is rewritten.
- R7: `idle_ack_o` falls after the first edge at which `idle_req_i` is sampled low.
- R8: `iclk_en_o` is low only while an acknowledge granted under policy 2 with clock field 0 is held and `idle_req_i` is high. It returns high combinationally as soon as `idle_req_i` goes low. It stays high for an acknowledge granted with a nonzero clock field or under policy 0.
- R9: `iclk_en_o` is never low while `idle_ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word: policy in [4:3], clock field in [9:8] |
| idle_req_i | input | 1 | Idle request from the power manager |
| bus_busy_i | input | 1 | Peripheral has a bus transaction outstanding |
| irq_pend_i | input | 1 | Peripheral has an interrupt outstanding |
| dma_pend_i | input | 1 | Peripheral has a DMA request outstanding |
| iclk_busy_i | input | 1 | Activity in the interface-clock domain |
| fclk_busy_i | input | 1 | Activity in the functional-clock domain |
| idle_ack_o | output | 1 | Idle acknowledge (registered) |
| iclk_en_o | output | 1 | Interface-clock gate enable |

## Verification
Under the waiting policy the request is held while each activity flag is raised alone in turn. This shows that every flag blocks the acknowledge on its own, and that the acknowledge comes one cycle after all of them clear. The same flag patterns are applied under the immediate policy and under the never and reserved policies. Each policy then gives a different outcome for identical activity. Raising only the interface-clock flag, first with clock field 0 and then with a nonzero value, separates the two clock options. Flooding the flags and rewriting the configuration while the acknowledge is held, then dropping the request, shows that the acknowledge holds and that the clock enable comes back before the acknowledge falls.

// File: rtl/idle_ack_pkg.sv
package idle_ack_pkg;

  typedef enum logic [1:0] {
    POL_IMMEDIATE = 2'd0,
    POL_NEVER     = 2'd1,
    POL_WAIT      = 2'd2,
    POL_RESERVED  = 2'd3
  } idle_pol_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_ACK  = 2'd2
  } ack_state_e;

  localparam int unsigned N_ACT    = 5;
  localparam int unsigned ACT_BUS  = 0;
  localparam int unsigned ACT_IRQ  = 1;
  localparam int unsigned ACT_DMA  = 2;
  localparam int unsigned ACT_ICLK = 3;
  localparam int unsigned ACT_FCLK = 4;

endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs
  import idle_ack_pkg::*;
#(
  parameter int unsigned CFG_W      = 32,
  parameter int unsigned POL_LSB    = 3,
  parameter int unsigned CLKACT_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output idle_pol_e        pol_o,
  output logic [1:0]       clkact_o
);
  idle_pol_e  pol_q, pol_d;
  logic [1:0] clkact_q, clkact_d;
  logic       unused_cfg;

  assign unused_cfg = ^wdata_i;

  always_comb begin
    pol_d    = pol_q;
    clkact_d = clkact_q;
    if (wr_i) begin
      pol_d    = idle_pol_e'(wdata_i[POL_LSB +: 2]);
      clkact_d = wdata_i[CLKACT_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q    <= POL_NEVER;
      clkact_q <= 2'd0;
    end else begin
      pol_q    <= pol_d;
      clkact_q <= clkact_d;
    end
  end

  assign pol_o    = pol_q;
  assign clkact_o = clkact_q;

  a_r1_cfg_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> (pol_q == idle_pol_e'($past(wdata_i[POL_LSB +: 2]))) &&
             (clkact_q == $past(wdata_i[CLKACT_LSB +: 2])));
endmodule

// File: rtl/idle_quiet_det.sv
module idle_quiet_det
  import idle_ack_pkg::*;
#(
  parameter int unsigned NACT     = N_ACT,
  parameter int unsigned ICLK_IDX = ACT_ICLK
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NACT-1:0] act_i,
  input  logic            skip_iclk_i,
  output logic            quiet_o
);
  logic [NACT-1:0] counted;

  for (genvar g = 0; g < NACT; g++) begin : g_act
    if (g == ICLK_IDX) begin : g_iclk
      assign counted[g] = act_i[g] & ~skip_iclk_i;
    end else begin : g_other
      assign counted[g] = act_i[g];
    end
  end

  assign quiet_o = ~|counted;

  a_r5_iclk_skipped: assert property (@(posedge clk) disable iff (!rst_ni)
    (skip_iclk_i && ($countones(act_i) == 1) && act_i[ICLK_IDX]) |-> quiet_o);
  a_r4_any_flag_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    ((act_i & ~(NACT'(1) << ICLK_IDX)) != '0) |-> !quiet_o);
endmodule

// File: rtl/idle_ack_fsm.sv
module idle_ack_fsm
  import idle_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req_i,
  input  idle_pol_e  pol_i,
  input  logic [1:0] clkact_i,
  input  logic       quiet_i,
  output logic       ack_o,
  output logic       gate_o
);
  ack_state_e st_q, st_d;
  logic       ack_q, ack_d;
  logic       gate_q, gate_d;
  logic       grant;
  logic       gate_sel;

  always_comb begin
    unique case (pol_i)
      POL_IMMEDIATE: grant = 1'b1;
      POL_WAIT:      grant = quiet_i;
      default:       grant = 1'b0;
    endcase
    gate_sel = (pol_i == POL_WAIT) && (clkact_i == 2'd0);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (req_i) st_d = grant ? ST_ACK : ST_PEND;
      ST_PEND: if (!req_i) st_d = ST_RUN;
               else if (grant) st_d = ST_ACK;
      ST_ACK:  if (!req_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
    ack_d  = (st_d == ST_ACK);
    gate_d = 1'b0;
    if (st_d == ST_ACK) gate_d = (st_q == ST_ACK) ? gate_q : gate_sel;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      ack_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      gate_q <= gate_d;
    end
  end

  assign ack_o  = ack_q;
  assign gate_o = gate_q;

  a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_ni)
    (pol_i == POL_IMMEDIATE && req_i && !ack_q) |=> ack_q);
  a_r3_never: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pol_i == POL_NEVER || pol_i == POL_RESERVED) && !ack_q) |=> !ack_q);
  a_r4_wait_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (pol_i == POL_WAIT && !quiet_i && !ack_q) |=> !ack_q);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_q && req_i) |=> ack_q);
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_i |=> !ack_q);
  a_r9_gate_needs_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    !ack_q |-> !gate_q);
endmodule

// File: rtl/idle_ack_ctrl.sv
module idle_ack_ctrl
  import idle_ack_pkg::*;
#(
  parameter int unsigned CFG_W      = 32,
  parameter int unsigned POL_LSB    = 3,
  parameter int unsigned CLKACT_LSB = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             idle_req_i,
  input  logic             bus_busy_i,
  input  logic             irq_pend_i,
  input  logic             dma_pend_i,
  input  logic             iclk_busy_i,
  input  logic             fclk_busy_i,
  output logic             idle_ack_o,
  output logic             iclk_en_o
);
  logic             rst_i_n;
  idle_pol_e        pol;
  logic [1:0]       clkact;
  logic [N_ACT-1:0] act;
  logic             quiet;
  logic             gate;

  idle_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  idle_cfg_regs #(.CFG_W(CFG_W), .POL_LSB(POL_LSB), .CLKACT_LSB(CLKACT_LSB)) u_cfg (
    .clk(clk), .rst_ni(rst_i_n), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
    .pol_o(pol), .clkact_o(clkact)
  );

  always_comb begin
    act           = '0;
    act[ACT_BUS]  = bus_busy_i;
    act[ACT_IRQ]  = irq_pend_i;
    act[ACT_DMA]  = dma_pend_i;
    act[ACT_ICLK] = iclk_busy_i;
    act[ACT_FCLK] = fclk_busy_i;
  end

  idle_quiet_det #(.NACT(N_ACT), .ICLK_IDX(ACT_ICLK)) u_quiet (
    .clk(clk), .rst_ni(rst_i_n), .act_i(act),
    .skip_iclk_i(clkact != 2'd0), .quiet_o(quiet)
  );

  idle_ack_fsm u_fsm (
    .clk(clk), .rst_ni(rst_i_n), .req_i(idle_req_i), .pol_i(pol),
    .clkact_i(clkact), .quiet_i(quiet), .ack_o(idle_ack_o), .gate_o(gate)
  );

  assign iclk_en_o = ~(gate & idle_req_i);

  a_r9_en_without_ack: assert property (@(posedge clk) disable iff (!rst_i_n)
    !idle_ack_o |-> iclk_en_o);
  a_r8_en_on_release: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pol != POL_WAIT && !idle_ack_o) |=> iclk_en_o);
endmodule

// File: tb/sim_idle_ack_ctrl.sv
module sim_idle_ack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic        bus_b = 1'b0, irq_p = 1'b0, dma_p = 1'b0, iclk_b = 1'b0, fclk_b = 1'b0;
  logic        ack, en;

  int checks = 0;
  int errors = 0;
  bit    q_ack[$];
  bit    q_en[$];
  string q_tag[$];

  always #10 clk = ~clk;

  idle_ack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .idle_req_i(req), .bus_busy_i(bus_b), .irq_pend_i(irq_p), .dma_pend_i(dma_p),
    .iclk_busy_i(iclk_b), .fclk_busy_i(fclk_b), .idle_ack_o(ack), .iclk_en_o(en)
  );

  task automatic check(input bit ea, input bit ee, input string tag);
    checks++;
    if (ack !== ea || en !== ee) begin
      errors++;
      $display("FAIL %s: ack=%b en=%b expected ack=%b en=%b", tag, ack, en, ea, ee);
    end
  endtask

  // monitor: compares scoreboard entries mid-cycle after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q_ack.size() > 0) check(q_ack.pop_front(), q_en.pop_front(), q_tag.pop_front());
    end
  end

  // flags order: {fclk, iclk, dma, irq, bus}
  task automatic cyc(input bit r, input logic [4:0] f, input bit ea, input bit ee, input string tag);
    @(negedge clk);
    req = r;
    {fclk_b, iclk_b, dma_p, irq_p, bus_b} = f;
    @(posedge clk);
    q_ack.push_back(ea); q_en.push_back(ee); q_tag.push_back(tag);
  endtask

  task automatic wr_cfg(input logic [1:0] pol, input logic [1:0] ca);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 32'hFFFF_FCE7 & ~32'h0000_0318;
    cfg_wdata[4:3] = pol;
    cfg_wdata[9:8] = ca;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5 check(1'b0, 1'b1, "R1 reset state");

    cyc(1, 5'h00, 0, 1, "R1 default policy never");
    cyc(1, 5'h00, 0, 1, "R3 never holds off");
    cyc(0, 5'h00, 0, 1, "R3 release");

    wr_cfg(2'd0, 2'd0);
    cyc(1, 5'h1f, 1, 1, "R2 immediate with all busy");
    cyc(1, 5'h1f, 1, 1, "R6 hold under activity");
    wr_cfg(2'd1, 2'd0);
    cyc(1, 5'h00, 1, 1, "R6 hold across config write");
    cyc(0, 5'h00, 0, 1, "R7 drop after release");
    cyc(1, 5'h00, 0, 1, "R3 never after rewrite");
    cyc(0, 5'h00, 0, 1, "R7 idle");

    wr_cfg(2'd3, 2'd0);
    cyc(1, 5'h00, 0, 1, "R3 reserved value");
    cyc(1, 5'h00, 0, 1, "R3 reserved value held");
    cyc(0, 5'h00, 0, 1, "R7 idle");

    wr_cfg(2'd2, 2'd0);
    cyc(1, 5'h01, 0, 1, "R4 bus blocks");
    cyc(1, 5'h02, 0, 1, "R4 irq blocks");
    cyc(1, 5'h04, 0, 1, "R4 dma blocks");
    cyc(1, 5'h10, 0, 1, "R4 fclk blocks");
    cyc(1, 5'h08, 0, 1, "R4 iclk blocks with field 0");
    cyc(1, 5'h00, 1, 0, "R8 ack and gate when quiet");
    cyc(1, 5'h1f, 1, 0, "R6 hold while busy again");
    @(negedge clk);
    req = 1'b0;
    {fclk_b, iclk_b, dma_p, irq_p, bus_b} = 5'h00;
    #1 check(1'b1, 1'b1, "R8 enable back before ack falls");
    @(posedge clk);
    #5 check(1'b0, 1'b1, "R7 ack falls after release");

    wr_cfg(2'd2, 2'd1);
    cyc(1, 5'h08, 1, 1, "R5 iclk ignored, clock kept");
    cyc(0, 5'h00, 0, 1, "R7 idle");
    cyc(1, 5'h01, 0, 1, "R5 bus still blocks");
    cyc(1, 5'h00, 1, 1, "R5 ack without gating");
    cyc(0, 5'h00, 0, 1, "R9 enable high with ack low");

    wr_cfg(2'd0, 2'd0);
    cyc(1, 5'h00, 1, 1, "R8 immediate policy keeps clock");
    cyc(0, 5'h00, 0, 1, "R7 idle");

    @(posedge clk);
    #8;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expected end, got timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule